// File: doc/BRIEF.md
# Dual-output serial flash read responder

This block is the target side of a serial flash link that answers one command: a fast read that returns data on two lines at once. Chip select low opens a transaction. A single serial input line then carries an 8-bit command, a 24-bit start address and an 8-clock dummy gap, one bit per rising edge of the serial clock. After that, the block streams bytes from its internal array two bits per clock on data lines 0 and 1. It updates both lines on falling edges. The address moves forward after every byte and wraps at the top of the array, so one command can read forever.

The serial clock, chip select and serial input are sampled by a faster system clock through a short synchronizer. All protocol decisions are taken on the edges detected there, so the whole block sits in a single clock domain and its array maps onto block RAM. A plain write port on the system clock fills the array before use.

Top module: `dual_read_responder`

## Requirements
- R1: After synchronous reset, both output enables (`dq0_oe`, `dq1_oe`) are 0.
- R2: While chip select is low, the block samples `sdi` on each rising serial clock edge, most significant bit first. It takes 8 command bits, then 24 address bits, then 8 dummy bits. Both output enables stay 0 throughout these 40 clocks.
- R3: When the command is 0x3B, each byte is sent in 4 beats in the order bits (7,6), (5,4), (3,2), (1,0). The output changes on the falling edges of the serial clock, starting with the falling edge that follows the 40th rising edge. On each beat `dq1_o` carries the higher bit and `dq0_o` the lower bit, and both enables are 1.
- R4: The first byte comes from the start address. The address then increases by one after each complete byte, with no gap between bytes.
- R5: Only the low log2(DEPTH) address bits select an array entry; the higher address bits have no effect. After entry DEPTH-1 the stream continues at entry 0.
- R6: Any command code other than 0x3B makes the block ignore the rest of the transaction. Both output enables stay 0 until chip select goes high.
- R7: Chip select going high at any point clears both output enables within a few system clocks and resets the bit counting. The next transaction is decoded from its first bit.
- R8: A system-clock cycle with `wr_en` high stores `wr_data` at array entry `wr_addr`. Later reads return that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial command/address input |
| wr_en | input | 1 | Array preload write strobe |
| wr_addr | input | log2(DEPTH) | Array preload address |
| wr_data | input | 8 | Array preload data |
| dq0_o | output | 1 | Data line 0 value (lower bit of each beat) |
| dq0_oe | output | 1 | Data line 0 drive enable |
| dq1_o | output | 1 | Data line 1 value (higher bit of each beat) |
| dq1_oe | output | 1 | Data line 1 drive enable |

## Verification
Reads start at a low address, at an address whose upper bits are nonzero, and just below the top of the array. These three cases separate correct beat ordering and incrementing from truncation of the address and from the wrap to entry 0. A wrong command code tests that the ignore path never drives either line. Chip select is raised in the middle of the address and again in the middle of a data byte, and the read that follows must still be correct; this shows whether abort fully clears the counters. Rewriting one entry after preload and reading it back shows that the write port and the read path agree.

// File: rtl/dual_read_pkg.sv
package dual_read_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } rd_state_e;
endpackage

// File: rtl/drr_sync.sv
module drr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/drr_mem.sv
module drr_mem #(
  parameter int DEPTH = 256,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[wa] <= wd;
    rq <= ram[ra];
  end

  // R8: a write lands in the array
  a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> ram[$past(wa)] == $past(wd));
endmodule

// File: rtl/drr_ctrl.sv
module drr_ctrl
  import dual_read_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int ADDR_BITS = 24,
  parameter int CMD_BITS = 8,
  parameter int DUMMY_CYCLES = 8,
  parameter logic [CMD_BITS-1:0] CMD_CODE = 8'h3B,
  localparam int AW = $clog2(DEPTH),
  localparam int SH_BITS = CMD_BITS + ADDR_BITS,
  localparam int HDR_BITS = SH_BITS + DUMMY_CYCLES,
  localparam int CW = $clog2(HDR_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          dq0_o,
  output logic          dq0_oe,
  output logic          dq1_o,
  output logic          dq1_oe
);
  rd_state_e          state;
  logic               sck_q;
  logic               rise_ev, fall_ev;
  logic [CW-1:0]      cnt;
  logic [SH_BITS-1:0] sh, sh_next;
  logic [1:0]         beat;
  logic [5:0]         hold;

  assign rise_ev = sck_s & ~sck_q & ~cs_s;
  assign fall_ev = ~sck_s & sck_q & ~cs_s;
  assign sh_next = {sh[SH_BITS-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      beat   <= '0;
      dq0_oe <= 1'b0;
      dq1_oe <= 1'b0;
      if (rst) begin
        rd_addr <= '0;
        hold    <= '0;
        dq0_o   <= 1'b0;
        dq1_o   <= 1'b0;
      end
    end else begin
      if (state == ST_IDLE) state <= ST_CMD;
      if (rise_ev && state != ST_DATA && state != ST_SKIP) begin
        cnt <= cnt + 1'b1;
        sh  <= sh_next;
        if (cnt == CW'(CMD_BITS - 1)) begin
          state <= (sh_next[CMD_BITS-1:0] == CMD_CODE) ? ST_ADDR : ST_SKIP;
        end else if (cnt == CW'(SH_BITS - 1)) begin
          rd_addr <= sh_next[AW-1:0];
          state   <= ST_DUMMY;
        end else if (cnt == CW'(HDR_BITS - 1)) begin
          state <= ST_DATA;
        end
      end
      if (fall_ev && state == ST_DATA) begin
        dq0_oe <= 1'b1;
        dq1_oe <= 1'b1;
        beat   <= beat + 1'b1;
        if (beat == 2'd0) begin
          dq1_o <= rd_data[7];
          dq0_o <= rd_data[6];
          hold  <= rd_data[5:0];
        end else begin
          dq1_o <= hold[5];
          dq0_o <= hold[4];
          hold  <= {hold[3:0], 2'b00};
        end
        if (beat == 2'd3) rd_addr <= rd_addr + 1'b1;
      end
    end
  end

  // R7: chip select high releases both lines
  a_r7_cs_release: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (!dq0_oe && !dq1_oe));

  // R3: data lines move only after a falling serial edge
  a_r3_fall_only: assert property (@(posedge clk) disable iff (rst)
    !fall_ev |=> ($stable(dq0_o) && $stable(dq1_o)));

  // R3: both lines are enabled together
  a_r3_oe_pair: assert property (@(posedge clk) disable iff (rst)
    dq0_oe == dq1_oe);

  // R6: an unknown command never drives the lines
  a_r6_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |=> !dq1_oe);

  // R2: no drive while the header is still arriving
  a_r2_header_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMD || state == ST_ADDR || state == ST_DUMMY) |-> !dq0_oe);
endmodule

// File: rtl/dual_read_responder.sv
module dual_read_responder #(
  parameter int DEPTH = 256,
  parameter int ADDR_BITS = 24,
  parameter int DUMMY_CYCLES = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] CMD_CODE = 8'h3B,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          sdi,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          dq0_o,
  output logic          dq0_oe,
  output logic          dq1_o,
  output logic          dq1_oe
);
  logic [2:0]    sync_q;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  drr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sdi, sck, cs_n}),
    .q   (sync_q)
  );

  drr_mem #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk (clk),
    .rst (rst),
    .we  (wr_en),
    .wa  (wr_addr),
    .wd  (wr_data),
    .ra  (rd_addr),
    .rq  (rd_data)
  );

  drr_ctrl #(
    .DEPTH(DEPTH), .ADDR_BITS(ADDR_BITS), .CMD_BITS(8),
    .DUMMY_CYCLES(DUMMY_CYCLES), .CMD_CODE(CMD_CODE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (sync_q[0]),
    .sck_s   (sync_q[1]),
    .sdi_s   (sync_q[2]),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .dq0_o   (dq0_o),
    .dq0_oe  (dq0_oe),
    .dq1_o   (dq1_o),
    .dq1_oe  (dq1_oe)
  );
endmodule

// File: tb/dual_read_responder_tb_top.sv
module dual_read_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);
  localparam int HALF = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic dq0_o, dq0_oe, dq1_o, dq1_oe;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  string exp_tag [$];
  logic in_data = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_read_responder #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dq0_o(dq0_o), .dq0_oe(dq0_oe), .dq1_o(dq1_o), .dq1_oe(dq1_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: assembles beats into bytes and compares with the scoreboard
  int beat_n = 0;
  logic [7:0] got = '0;
  logic oe_ok = 1'b1;
  always @(posedge sck) begin
    if (!in_data) begin
      beat_n = 0;
      oe_ok = 1'b1;
    end else begin
      got = {got[5:0], dq1_o, dq0_o};
      if (!(dq0_oe && dq1_oe)) oe_ok = 1'b0;
      beat_n++;
      if (beat_n == 4) begin
        beat_n = 0;
        if (exp_q.size() == 0) begin
          check("R3 unexpected byte", {24'd0, got}, 32'hFFFF_FFFF);
        end else begin
          check(exp_tag.pop_front(), {24'd0, got}, {24'd0, exp_q.pop_front()});
          check("R3 enables during data", {31'd0, oe_ok}, 32'd1);
        end
        oe_ok = 1'b1;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic hdr_quiet;
  task automatic sck_cycle(input logic d);
    sdi = d;
    wait_clk(HALF);
    sck = 1'b1;
    if (dq0_oe || dq1_oe) hdr_quiet = 1'b0;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic send_header(input logic [7:0] cmd, input logic [23:0] addr);
    for (int i = 7; i >= 0; i--) sck_cycle(cmd[i]);
    for (int i = 23; i >= 0; i--) sck_cycle(addr[i]);
    for (int i = 0; i < 8; i++) sck_cycle(1'b0);
  endtask

  task automatic end_txn();
    in_data = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  // Driver: pushes expected bytes, then clocks the read
  task automatic read_txn(input logic [23:0] addr, input int nbytes, input string tag);
    for (int k = 0; k < nbytes; k++) begin
      exp_q.push_back(model[(int'(addr) + k) % DEPTH]);
      exp_tag.push_back(tag);
    end
    hdr_quiet = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    send_header(8'h3B, addr);
    check("R2 lines quiet during header", {31'd0, hdr_quiet}, 32'd1);
    in_data = 1'b1;
    for (int k = 0; k < 4 * nbytes; k++) sck_cycle(1'b0);
    end_txn();
    check("R4 scoreboard drained", exp_q.size(), 32'd0);
  endtask

  task automatic write_mem(input int a, input logic [7:0] v);
    wr_addr = AW'(a);
    wr_data = v;
    wr_en = 1'b1;
    wait_clk(1);
    wr_en = 1'b0;
    model[a] = v;
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    check("R1 reset enables", {30'd0, dq1_oe, dq0_oe}, 32'd0);

    for (int i = 0; i < DEPTH; i++) write_mem(i, 8'((i * 37 + 11) & 8'hFF));

    read_txn(24'h000010, 6, "R3/R4 basic stream");
    read_txn(24'hABCD05, 3, "R5 upper address bits ignored");
    read_txn(24'h0000FE, 5, "R5 wrap to entry 0");

    // R6: unknown command
    hdr_quiet = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    send_header(8'h0B, 24'h000010);
    for (int k = 0; k < 16; k++) sck_cycle(1'b0);
    check("R6 unknown command stays quiet", {31'd0, hdr_quiet}, 32'd1);
    end_txn();

    // R7: abort in the middle of the address
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) sck_cycle(1'(8'h3B >> i));
    for (int i = 0; i < 12; i++) sck_cycle(1'b1);
    end_txn();
    read_txn(24'h000030, 2, "R7 read after address abort");

    // R7: abort in the middle of a data byte
    exp_q.push_back(model[8'h40]);
    exp_tag.push_back("R7 byte before data abort");
    cs_n = 1'b0;
    wait_clk(HALF);
    send_header(8'h3B, 24'h000040);
    in_data = 1'b1;
    for (int k = 0; k < 4; k++) sck_cycle(1'b0);
    in_data = 1'b0;
    sck_cycle(1'b0);
    sck_cycle(1'b0);
    cs_n = 1'b1;
    wait_clk(8);
    check("R7 enables cleared on abort", {30'd0, dq1_oe, dq0_oe}, 32'd0);
    wait_clk(3 * HALF);
    read_txn(24'h000041, 2, "R7 read after data abort");

    // R8: rewrite one entry and read it back
    write_mem(8'h30, 8'h5A);
    read_txn(24'h00002F, 3, "R8 rewritten entry");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule